// File: doc/BRIEF.md
# Dual Pulse Position-Width Modulator

This block turns two per-period duty requests into two discrete conversion-function waveforms. Channel A is unipolar: its output is 0 or 1. Channel B is ternary: its output is 0, +1 or -1. The modulation period is a programmable number of clock cycles. Each channel has a programmable pulse width and start position, both counted in clock cycles. Over one frame, the number of active cycles equals the requested width, so the frame mean equals the average reference.

A mode input chooses how the two pulses are placed:
- **Chained placement:** the B pulse cannot begin before the A pulse has ended.
- **Aligned placement:** both pulses begin at the A position.

Where the two waveforms would overlap with B at +1, the combination (A=1, B=+1) is suppressed.

All requests are captured once per frame, in the frame's final cycle. A one-cycle strobe marks the first cycle of each frame, so the reference generator upstream knows when to present new values. When a pulse does not fit inside the frame, it is cut at the frame end, and a flag is held high for that frame.

Top module: `dual_pulse_mod`

## Requirements
- R1: Frame cycles are numbered from 0. `m1_out` is 1 exactly in the cycles n with pos_a ≤ n < min(pos_a+wid_a, P), where P is the captured period. Otherwise `m1_out` is 0. When nothing is clipped, it is high for exactly wid_a cycles.
- R2: `m2_out` uses the encoding 2'b00 for 0, 2'b01 for +1 and 2'b11 for -1. The value 2'b10 never appears. While B's pulse is active, its polarity follows `neg_b`, as captured for that frame (1 gives -1).
- R3: A frame lasts P cycles, where P = `period_len`, and a `period_len` of 0 is treated as 1. `frame_start` is high only in cycle 0 of each frame.
- R4: The inputs (period, widths, positions, sign, mode) are sampled only on the clock edge that ends a frame, and on the first edge after reset. Changes made in the middle of a frame do not affect that frame.
- R5: In chained mode (`sim_mode`=0), B's pulse starts at max(pos_b, end of A's pulse) and lasts min(wid_b, P − start) cycles.
- R6: In aligned mode (`sim_mode`=1), B's pulse starts at pos_a, and `pos_b` is ignored.
- R7: `clip_flag` is high for the whole of a frame in which pos_a+wid_a > P, or in which B's start plus wid_b > P. The clipped pulse ends at the frame end.
- R8: `m1_out`=1 together with `m2_out`=+1 never occurs. In cycles where both pulses are active with positive sign, `m2_out` is forced to 0.
- R9: While `rst_n` is low, all outputs are 0. The first frame begins one cycle after reset is released, with `frame_start` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| period_len | input | CW | frame length in cycles |
| wid_a | input | CW | channel A pulse width |
| pos_a | input | CW | channel A start position |
| wid_b | input | CW | channel B pulse width |
| pos_b | input | CW | channel B start position (chained mode) |
| neg_b | input | 1 | channel B polarity, 1 = negative |
| sim_mode | input | 1 | 1 = aligned placement, 0 = chained |
| m1_out | output | 1 | unipolar conversion function |
| m2_out | output | 2 | ternary conversion function |
| frame_start | output | 1 | first cycle of a frame |
| clip_flag | output | 1 | a pulse was cut at the frame end |

## Verification
The assertions check several properties on every cycle:
- the A=1, B=+1 combination never appears;
- the 2'b10 code never appears on `m2_out`;
- the frame counter advances by one between frame ends, and a strobe follows every frame end;
- the captured settings and the flag stay constant mid-frame.

The exact pulse placement needs the bench's cycle-by-cycle model. That covers the chained start at the later of pos_b and A's end, the aligned start, the clipping arithmetic, the zero-period case and the ignoring of mid-frame input changes.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef enum logic [1:0] {
    M2_ZERO = 2'b00,
    M2_POS  = 2'b01,
    M2_NEG  = 2'b11
  } m2_code_e;

  typedef enum logic {
    PLACE_CHAINED = 1'b0,
    PLACE_ALIGNED = 1'b1
  } place_e;
endpackage

// File: rtl/dpm_frame_ctr.sv
module dpm_frame_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] per_q,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  localparam logic [CW:0] ONE = (CW+1)'(1);

  // last cycle of a frame; also true while no period has been captured
  assign wrap = ({1'b0, cnt} + ONE) >= {1'b0, per_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dpm_window.sv
module dpm_window #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] cnt,
  input  logic [CW:0]   lo,
  input  logic [CW:0]   hi,
  output logic          act
);
  logic [CW:0] cnt_w;
  assign cnt_w = {1'b0, cnt};
  assign act   = (cnt_w >= lo) && (cnt_w < hi);
endmodule

// File: rtl/dual_pulse_mod.sv
module dual_pulse_mod
  import dpm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period_len,
  input  logic [CW-1:0] wid_a,
  input  logic [CW-1:0] pos_a,
  input  logic [CW-1:0] wid_b,
  input  logic [CW-1:0] pos_b,
  input  logic          neg_b,
  input  logic          sim_mode,
  output logic          m1_out,
  output logic [1:0]    m2_out,
  output logic          frame_start,
  output logic          clip_flag
);
  localparam int          NCH = 2;
  localparam logic [CW:0] ONE = (CW+1)'(1);

  function automatic logic [CW:0] min_w(input logic [CW:0] x, input logic [CW:0] y);
    return (x < y) ? x : y;
  endfunction

  function automatic logic [CW:0] max_w(input logic [CW:0] x, input logic [CW:0] y);
    return (x > y) ? x : y;
  endfunction

  function automatic logic [CW:0] eff_period(input logic [CW-1:0] p);
    return (p == '0) ? ONE : {1'b0, p};
  endfunction

  // captured frame state
  logic [CW-1:0] per_q;
  logic [CW:0]   lo_q [NCH];
  logic [CW:0]   hi_q [NCH];
  logic          neg_q, sim_q, clip_q;

  // named internal events
  logic          frame_load;
  logic [CW-1:0] cnt;
  logic [NCH-1:0] act;
  logic          m2_blocked;

  // placement arithmetic for the frame being loaded
  logic [CW:0] pe, reach_a, end_a, start_b, reach_b, end_b;
  logic        clip_nx;

  always_comb begin
    pe      = eff_period(period_len);
    reach_a = {1'b0, pos_a} + {1'b0, wid_a};
    end_a   = min_w(reach_a, pe);
    start_b = (place_e'(sim_mode) == PLACE_ALIGNED) ? {1'b0, pos_a}
                                                   : max_w({1'b0, pos_b}, end_a);
    reach_b = start_b + {1'b0, wid_b};
    end_b   = min_w(reach_b, pe);
    clip_nx = (reach_a > pe) || (reach_b > pe);
  end

  dpm_frame_ctr #(.CW(CW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .per_q (per_q),
    .cnt   (cnt),
    .wrap  (frame_load)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      lo_q[0] <= '0; hi_q[0] <= '0;
      lo_q[1] <= '0; hi_q[1] <= '0;
      neg_q  <= 1'b0;
      sim_q  <= 1'b0;
      clip_q <= 1'b0;
    end else if (frame_load) begin
      per_q  <= pe[CW-1:0] | {{(CW-1){1'b0}}, pe[CW]};
      lo_q[0] <= {1'b0, pos_a};
      hi_q[0] <= end_a;
      lo_q[1] <= start_b;
      hi_q[1] <= end_b;
      neg_q  <= neg_b;
      sim_q  <= sim_mode;
      clip_q <= clip_nx;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_win
    dpm_window #(.CW(CW)) u_win (
      .cnt (cnt),
      .lo  (lo_q[ch]),
      .hi  (hi_q[ch]),
      .act (act[ch])
    );
  end

  assign m2_blocked  = act[0] && act[1] && !neg_q;
  assign m1_out      = act[0];
  assign m2_out      = (act[1] && !m2_blocked) ? (neg_q ? M2_NEG : M2_POS) : M2_ZERO;
  assign frame_start = (cnt == '0) && (per_q != '0);
  assign clip_flag   = clip_q;
endmodule

// File: rtl/dual_pulse_mod_chk.sv
module dual_pulse_mod_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_load,
  input logic [CW-1:0] cnt,
  input logic          frame_start,
  input logic          m1_out,
  input logic [1:0]    m2_out,
  input logic          m2_blocked,
  input logic          clip_flag,
  input logic          sim_q,
  input logic          neg_q
);
  AST_NO_A_AND_POS_B: assert property (@(posedge clk) disable iff (!rst_n)
    !(m1_out && m2_out == 2'b01)); // R8

  AST_BLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    m2_blocked |-> (m2_out == 2'b00)); // R8

  AST_M2_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    m2_out != 2'b10); // R2

  AST_STROBE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |=> frame_start); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_load |=> (cnt == $past(cnt) + 1'b1)); // R3

  AST_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_load |=> ($stable(clip_flag) && $stable(sim_q) && $stable(neg_q))); // R4
endmodule

bind dual_pulse_mod dual_pulse_mod_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_load  (frame_load),
  .cnt         (cnt),
  .frame_start (frame_start),
  .m1_out      (m1_out),
  .m2_out      (m2_out),
  .m2_blocked  (m2_blocked),
  .clip_flag   (clip_flag),
  .sim_q       (sim_q),
  .neg_q       (neg_q)
);

// File: tb/dual_pulse_mod_test.sv
module dual_pulse_mod_test;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] period_len = '0, wid_a = '0, pos_a = '0, wid_b = '0, pos_b = '0;
  logic          neg_b = 1'b0, sim_mode = 1'b0;
  logic          m1_out, frame_start, clip_flag;
  logic [1:0]    m2_out;

  int total = 0;
  int bad = 0;
  string sc = "R9";

  always #2 clk = ~clk;

  dual_pulse_mod #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .period_len(period_len),
    .wid_a(wid_a), .pos_a(pos_a), .wid_b(wid_b), .pos_b(pos_b),
    .neg_b(neg_b), .sim_mode(sim_mode),
    .m1_out(m1_out), .m2_out(m2_out), .frame_start(frame_start), .clip_flag(clip_flag)
  );

  // behavioural reference: a frame position and the two intervals
  int mper = 0, mpos = 0, a_lo = 0, a_hi = 0, b_lo = 0, b_hi = 0;
  bit mneg = 0, mclip = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mper = 0; mpos = 0; a_lo = 0; a_hi = 0; b_lo = 0; b_hi = 0;
      mneg = 0; mclip = 0;
    end else if (mpos + 1 >= mper) begin
      int p;
      p = (int'(period_len) == 0) ? 1 : int'(period_len);
      a_lo = int'(pos_a);
      a_hi = (a_lo + int'(wid_a) < p) ? a_lo + int'(wid_a) : p;
      if (sim_mode) b_lo = a_lo;
      else          b_lo = (int'(pos_b) > a_hi) ? int'(pos_b) : a_hi;
      b_hi = (b_lo + int'(wid_b) < p) ? b_lo + int'(wid_b) : p;
      mclip = (int'(pos_a) + int'(wid_a) > p) || (b_lo + int'(wid_b) > p);
      mneg = neg_b;
      mper = p;
      mpos = 0;
    end else begin
      mpos = mpos + 1;
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s [%s] %s got=%0d exp=%0d at %0t", req, sc, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit e1, eb;
    int e2;
    e1 = (mpos >= a_lo) && (mpos < a_hi);
    eb = (mpos >= b_lo) && (mpos < b_hi);
    if (eb && !(e1 && !mneg)) e2 = mneg ? 3 : 1;
    else                      e2 = 0;
    chk("R1", "m1_out", int'(m1_out), int'(e1));
    chk("R2", "m2_out", int'(m2_out), e2);
    chk("R3", "frame_start", int'(frame_start), int'(mpos == 0 && mper != 0));
    chk("R7", "clip_flag", int'(clip_flag), int'(mclip));
  end

  task automatic setup(input string tag, input int per, input int wa, input int pa,
                       input int wb, input int pb, input bit ng, input bit sm);
    sc = tag;
    period_len = CW'(per); wid_a = CW'(wa); pos_a = CW'(pa);
    wid_b = CW'(wb); pos_b = CW'(pb); neg_b = ng; sim_mode = sm;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs idle in reset
    chk("R9", "reset m1", int'(m1_out), 0);
    chk("R9", "reset m2", int'(m2_out), 0);
    chk("R9", "reset strobe", int'(frame_start), 0);
    setup("R5", 10, 3, 1, 2, 0, 0, 0);          // chained, B right after A
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "first strobe", int'(frame_start), 1);
    repeat (30) @(negedge clk);
    setup("R5", 12, 3, 1, 2, 7, 1, 0);          // chained, B waits for pos_b
    repeat (36) @(negedge clk);
    setup("R1", 9, 4, 0, 5, 0, 0, 0);           // chained, fills the frame
    repeat (27) @(negedge clk);
    setup("R6", 8, 4, 2, 4, 6, 1, 1);           // aligned, negative B
    repeat (24) @(negedge clk);
    setup("R8", 8, 3, 1, 5, 0, 0, 1);           // aligned, positive overlap blocked
    repeat (24) @(negedge clk);
    setup("R7", 6, 5, 4, 2, 0, 0, 0);           // A and B clipped
    repeat (18) @(negedge clk);
    setup("R7", 10, 2, 1, 9, 5, 1, 0);          // only B clipped
    repeat (30) @(negedge clk);
    setup("R3", 0, 1, 0, 1, 0, 1, 1);           // zero period acts as one
    repeat (6) @(negedge clk);
    setup("R3", 1, 0, 0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    setup("R4", 20, 6, 3, 4, 12, 0, 0);
    repeat (27) @(negedge clk);                 // now mid-frame
    setup("R4", 7, 1, 0, 2, 1, 1, 1);           // must wait for frame end
    repeat (5) @(negedge clk);
    setup("R4", 15, 2, 9, 3, 0, 0, 0);
    repeat (40) @(negedge clk);
    setup("R2", 11, 0, 0, 4, 3, 1, 0);          // B alone, negative
    repeat (33) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule